// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt events for a small processor core and turns them into one registered request line with a program-memory vector address. Three external pins pass through synchronizers and edge detectors. Their falling and rising edges, together with a one-cycle pulse from an internal timer, set bits in a six-bit pending register. Each pending bit is gated by its own enable bit and by a global enable. A programmable priority setting then picks the request that is served.

The processor observes `irq_req_o` and `vec_o`. When it takes the interrupt it pulses `irq_ack`. The block then clears the pending bit it was presenting and clears the global enable, so no further interrupt is raised until software sets that enable again. Software reaches the pending, enable and priority registers through a simple write port and a registered read port. It can therefore poll the pending bits with interrupts disabled, and it can set or clear pending bits directly.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After synchronous reset, the pending, enable and priority registers are zero, `irq_req_o` is 0, `vec_o` is 0 and `rd_data` is 0. The pin synchronizers start at the idle-high level, so releasing reset with the pins high sets nothing.
- R2: Pending bit 0 is set by a falling edge on `pin_in[1]`, bit 1 by a falling edge on `pin_in[2]`, bit 2 by a falling edge on `pin_in[0]`, and bit 3 by a rising edge on `pin_in[1]`. A pin change driven before clock edge k is visible as a set bit (and on `irq_req_o`, if enabled) after clock edge k+2.
- R3: Pending bit 4 is reserved. It never becomes 1, and writing a 1 to it has no effect.
- R4: A `timer_evt` pulse sampled at a clock edge sets pending bit 5 at that same edge.
- R5: `irq_req_o` is 1 exactly when enable bit 7 (global) is 1 and some pending bit n has enable bit n set. It reflects the registers as updated at the same clock edge.
- R6: Priority code `prio[2:0]` orders three groups, A = {0,1}, B = {2,3} and C = {4,5}. The codes map as follows: 0 gives A>B>C, 1 gives A>C>B, 2 gives B>A>C, 3 gives B>C>A, 4 gives C>A>B, 5 gives C>B>A, and 6 and 7 behave as 0. Within a group, the lower request number wins.
- R7: While `irq_req_o` is 1, `vec_o` equals 2n, where n is the selected request; byte 2n+1 is implied. While `irq_req_o` is 0, `vec_o` is 0.
- R8: An `irq_ack` sampled while `irq_req_o` is 1 clears the pending bit of the presented request and clears the global enable at that edge. An `irq_ack` sampled while `irq_req_o` is 0 has no effect.
- R9: `rd_data` returns, one clock after sampling `rd_sel`, the value of the selected register. Select 0 gives the pending bits in [5:0], select 1 gives the enable byte, select 2 gives the priority in [2:0], and select 3 gives 0. Pending bits read back even while the global enable is off.
- R10: A write with `wr_en` and `wr_sel`=0 replaces pending bits [5:0]. Select 1 writes the enable byte (bit 7 global, bits 5..0 individual). Select 2 writes the priority from `wr_data[2:0]`. An event that sets a pending bit in the same cycle as a pending write overrides a written 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 3 | Asynchronous external event pins, idle high |
| timer_evt | input | 1 | One-cycle internal timer event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 pending, 1 enable, 2 priority |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read target, same encoding plus 3 = zero |
| rd_data | output | 8 | Registered read data |
| irq_ack | input | 1 | Processor accepts the presented interrupt |
| irq_req_o | output | 1 | Registered interrupt request to the processor |
| vec_o | output | 16 | Registered vector byte address of the selected request |

## Verification
A wrong pending or enable bit shows on `irq_req_o` and `vec_o` in the cycle right after the edge that stored it, because both outputs are computed from the register next state. The bench compares them every cycle against its own model. A lost acknowledge clear shows as the same vector appearing again as soon as the global enable is restored. A wrong ordering in the priority select shows as a wrong even address whenever two groups are pending. Register contents that do not reach the outputs, such as pending bits with the global enable off, surface on `rd_data` one cycle after the read select.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_REQ  = 6;
  localparam int NUM_PINS = 3;
  localparam int IDX_W    = $clog2(NUM_REQ);
  localparam int PRIO_W   = 3;

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PRIO = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= {STAGES{IDLE}};
      prev <= IDLE;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
  assign fall = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
(
  input  logic [NUM_REQ-1:0] pend,
  input  logic [PRIO_W-1:0]  prio,
  output logic               valid,
  output logic [IDX_W-1:0]   idx
);
  localparam int NUM_GRP = NUM_REQ / 2;

  logic [NUM_GRP-1:0] g_hit;
  logic [IDX_W-1:0]   g_idx [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign g_hit[g] = pend[2*g] | pend[2*g+1];
    assign g_idx[g] = pend[2*g] ? IDX_W'(2*g) : IDX_W'(2*g+1);
  end

  logic [1:0] o0, o1, o2;
  always_comb begin
    case (prio)
      3'd1:    begin o0 = 2'd0; o1 = 2'd2; o2 = 2'd1; end
      3'd2:    begin o0 = 2'd1; o1 = 2'd0; o2 = 2'd2; end
      3'd3:    begin o0 = 2'd1; o1 = 2'd2; o2 = 2'd0; end
      3'd4:    begin o0 = 2'd2; o1 = 2'd0; o2 = 2'd1; end
      3'd5:    begin o0 = 2'd2; o1 = 2'd1; o2 = 2'd0; end
      default: begin o0 = 2'd0; o1 = 2'd1; o2 = 2'd2; end
    endcase
  end

  always_comb begin
    valid = |g_hit;
    if (g_hit[o0])      idx = g_idx[o0];
    else if (g_hit[o1]) idx = g_idx[o1];
    else if (g_hit[o2]) idx = g_idx[o2];
    else                idx = '0;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int   ADDR_W      = 16,
  parameter int   DATA_W      = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          pin_in,
  input  logic                timer_evt,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [1:0]          rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                irq_ack,
  output logic                irq_req_o,
  output logic [ADDR_W-1:0]   vec_o
);
  localparam int GIE_BIT  = DATA_W - 1;
  localparam int RSV_REQ  = 4;
  localparam int TMR_REQ  = 5;

  logic [NUM_PINS-1:0] rise, fall;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    irq_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
      .clk (clk),
      .rst (rst),
      .pin (pin_in[p]),
      .rise(rise[p]),
      .fall(fall[p])
    );
  end

  logic [NUM_REQ-1:0] req_q, req_d, set_v, clr_v;
  logic [DATA_W-1:0]  mask_q, mask_d;
  logic [PRIO_W-1:0]  prio_q, prio_d;
  logic [IDX_W-1:0]   cur_idx, sel_idx;
  logic               sel_valid, ack_take, irq_d;

  always_comb begin
    set_v          = '0;
    set_v[0]       = fall[1];
    set_v[1]       = fall[2];
    set_v[2]       = fall[0];
    set_v[3]       = rise[1];
    set_v[TMR_REQ] = timer_evt;
  end

  assign ack_take = irq_ack & irq_req_o;
  assign clr_v    = ack_take ? (NUM_REQ'(1) << cur_idx) : '0;

  always_comb begin
    req_d = (wr_en && wr_sel == SEL_PEND) ? wr_data[NUM_REQ-1:0] : req_q;
    req_d = (req_d & ~clr_v) | set_v;
    req_d[RSV_REQ] = 1'b0;

    mask_d = (wr_en && wr_sel == SEL_EN) ? wr_data : mask_q;
    if (ack_take) mask_d[GIE_BIT] = 1'b0;

    prio_d = (wr_en && wr_sel == SEL_PRIO) ? wr_data[PRIO_W-1:0] : prio_q;
  end

  irq_prio_sel u_sel (
    .pend (req_d & mask_d[NUM_REQ-1:0]),
    .prio (prio_d),
    .valid(sel_valid),
    .idx  (sel_idx)
  );

  assign irq_d = mask_d[GIE_BIT] & sel_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= '0;
      mask_q    <= '0;
      prio_q    <= '0;
      cur_idx   <= '0;
      irq_req_o <= 1'b0;
      vec_o     <= '0;
      rd_data   <= '0;
    end else begin
      req_q     <= req_d;
      mask_q    <= mask_d;
      prio_q    <= prio_d;
      cur_idx   <= sel_idx;
      irq_req_o <= irq_d;
      vec_o     <= irq_d ? ADDR_W'({sel_idx, 1'b0}) : '0;
      case (rd_sel)
        SEL_PEND: rd_data <= DATA_W'(req_q);
        SEL_EN:   rd_data <= mask_q;
        SEL_PRIO: rd_data <= DATA_W'(prio_q);
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_ack,
  input logic              timer_evt,
  input logic              irq_req_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic [5:0]        req_q,
  input logic [DATA_W-1:0] mask_q
);
  p_rsv_low_r3: assert property (@(posedge clk) disable iff (rst) req_q[4] == 1'b0);
  p_timer_sets_r4: assert property (@(posedge clk) disable iff (rst) timer_evt |=> req_q[5]);
  p_gie_gate_r5: assert property (@(posedge clk) disable iff (rst) irq_req_o |-> mask_q[DATA_W-1]);
  p_vec_even_r7: assert property (@(posedge clk) disable iff (rst) vec_o[0] == 1'b0);
  p_vec_idle_r7: assert property (@(posedge clk) disable iff (rst) !irq_req_o |-> vec_o == '0);
  p_ack_gie_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req_o) |=> (!mask_q[DATA_W-1] && !irq_req_o));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_ack  (irq_ack),
  .timer_evt(timer_evt),
  .irq_req_o(irq_req_o),
  .vec_o    (vec_o),
  .req_q    (req_q),
  .mask_q   (mask_q)
);

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;
  logic        clk = 0, rst = 1;
  logic [2:0]  pin_in = 3'b111;
  logic        timer_evt = 0, wr_en = 0, irq_ack = 0;
  logic [1:0]  wr_sel = 0, rd_sel = 0;
  logic [7:0]  wr_data = 0, rd_data;
  logic        irq_req_o;
  logic [15:0] vec_o;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_vec_ctrl u0 (.clk(clk), .rst(rst), .pin_in(pin_in), .timer_evt(timer_evt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_ack(irq_ack), .irq_req_o(irq_req_o), .vec_o(vec_o));

  // Reference model built from the requirements
  logic [5:0]  m_req;
  logic [7:0]  m_mask, m_rd;
  logic [2:0]  m_prio;
  logic [2:0]  s1, s2, s3;
  logic        m_irq;
  logic [15:0] m_vec;

  function automatic int pick(input logic [5:0] p, input logic [2:0] c);
    int go[3];
    case (c)
      3'd1: go = '{0, 2, 1};
      3'd2: go = '{1, 0, 2};
      3'd3: go = '{1, 2, 0};
      3'd4: go = '{2, 0, 1};
      3'd5: go = '{2, 1, 0};
      default: go = '{0, 1, 2};
    endcase
    for (int k = 0; k < 3; k++)
      for (int j = 0; j < 2; j++)
        if (p[2*go[k]+j]) return 2*go[k]+j;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_req = 0; m_mask = 0; m_prio = 0; m_rd = 0;
      s1 = 3'b111; s2 = 3'b111; s3 = 3'b111;
      m_irq = 0; m_vec = 0;
    end else begin
      logic [2:0] fl, rs;
      logic [5:0] setv, clrv;
      int w;
      case (rd_sel)
        2'd0: m_rd = {2'b0, m_req};
        2'd1: m_rd = m_mask;
        2'd2: m_rd = {5'b0, m_prio};
        default: m_rd = 0;
      endcase
      fl = s3 & ~s2; rs = ~s3 & s2;
      setv = {timer_evt, 1'b0, rs[1], fl[0], fl[2], fl[1]};
      clrv = (irq_ack && m_irq) ? (6'd1 << m_vec[3:1]) : 6'd0;
      if (wr_en && wr_sel == 0) m_req = wr_data[5:0];
      m_req = (m_req & ~clrv) | setv;
      m_req[4] = 0;
      if (wr_en && wr_sel == 1) m_mask = wr_data;
      if (irq_ack && m_irq) m_mask[7] = 0;
      if (wr_en && wr_sel == 2) m_prio = wr_data[2:0];
      s3 = s2; s2 = s1; s1 = pin_in;
      w = pick(m_req & m_mask[5:0], m_prio);
      m_irq = m_mask[7] && (w >= 0);
      m_vec = m_irq ? 16'(2 * w) : 16'd0;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare all outputs against the model at the falling edge, then the caller drives
  task automatic cyc(input string tag);
    @(negedge clk);
    chk({tag, " irq"}, {15'b0, irq_req_o}, {15'b0, m_irq});
    chk({tag, " vec"}, vec_o, m_vec);
    chk({tag, " rd"}, {8'b0, rd_data}, {8'b0, m_rd});
    wr_en = 0; irq_ack = 0; timer_evt = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d, input string tag);
    wr_en = 1; wr_sel = s; wr_data = d;
    cyc(tag);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cyc("R1");
    chk("R1 irq", {15'b0, irq_req_o}, 16'd0);
    chk("R1 vec", vec_o, 16'd0);
    chk("R1 rd", {8'b0, rd_data}, 16'd0);
    cyc("R1");

    wr(2'd1, 8'hBF, "R10");
    cyc("R5");
    pin_in[1] = 0;
    cyc("R2");
    cyc("R2");
    chk("R2 timing early", {15'b0, irq_req_o}, 16'd0);
    cyc("R2");
    chk("R2 fall p1", {15'b0, irq_req_o}, 16'd1);
    chk("R7 vec req0", vec_o, 16'd0);
    pin_in[1] = 1;
    repeat (3) cyc("R2");
    chk("R6 req0 over req3", vec_o, 16'd0);
    irq_ack = 1;
    cyc("R8");
    chk("R8 ack drops irq", {15'b0, irq_req_o}, 16'd0);
    rd_sel = 0;
    cyc("R9");
    cyc("R9");
    chk("R9 poll pend", {8'b0, rd_data}, 16'h0008);
    wr(2'd1, 8'hBF, "R10");
    cyc("R7");
    chk("R7 vec req3", vec_o, 16'd6);

    pin_in[0] = 0; pin_in[2] = 0;
    repeat (4) cyc("R2");
    pin_in[0] = 1; pin_in[2] = 1;
    repeat (4) cyc("R2");

    wr(2'd0, 8'h3F, "R3");
    cyc("R3");
    chk("R3 rsv readback", {8'b0, rd_data}, 16'h002F);
    for (int c = 0; c < 8; c++) begin
      wr(2'd2, 8'(c), "R6");
      cyc("R6");
      chk("R6 order", vec_o, (c == 2 || c == 3) ? 16'd4 : (c == 4 || c == 5) ? 16'd10 : 16'd0);
    end
    wr(2'd0, 8'h0C, "R6");
    wr(2'd2, 8'd2, "R6");
    cyc("R6");
    chk("R6 tie low", vec_o, 16'd4);

    wr(2'd0, 8'h00, "R10");
    wr(2'd2, 8'd0, "R10");
    timer_evt = 1;
    cyc("R4");
    chk("R4 timer", vec_o, 16'd10);
    wr(2'd0, 8'h00, "R10");
    cyc("R10");
    timer_evt = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h00;
    cyc("R10");
    chk("R10 set beats write", vec_o, 16'd10);

    wr(2'd1, 8'h3F, "R8");
    irq_ack = 1;
    cyc("R8");
    rd_sel = 1;
    cyc("R8");
    cyc("R8");
    chk("R8 ignored ack mask", {8'b0, rd_data}, 16'h003F);
    rd_sel = 0;
    cyc("R8");
    cyc("R8");
    chk("R8 ignored ack pend", {8'b0, rd_data}, 16'h0020);

    void'($urandom(32'd1234));
    for (int i = 0; i < 5000; i++) begin
      logic [31:0] r;
      r = $urandom;
      for (int p = 0; p < 3; p++) if (r[p*3 +: 3] == 0) pin_in[p] = ~pin_in[p];
      timer_evt = (r[11:9] == 0);
      irq_ack   = m_irq && r[12];
      rd_sel    = r[14:13];
      if (r[17:15] == 0) begin
        wr_en = 1; wr_sel = 2'(r[19:18] % 3);
        wr_data = 8'($urandom);
        if (wr_sel == 1 && r[20]) wr_data[7] = 1;
      end
      cyc("R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule